// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path and handles the moment a core leaves normal flow for a handler. When the core raises the take strobe, the block looks at the pending exception and the external interrupt request. It decides which of the two, if either, is accepted. It then saves the architectural state and computes the handler address in a single clock edge.

The block owns the status register and its three shadow copies: the saved status, the saved program counter and the saved stack register. It also owns the two event-code registers and the new program counter. The core supplies its current PC, its R15, the vector base and its sleep and delay-slot state. The core receives the new PC together with a one-cycle done pulse, plus clear pulses for its sleep and delay-slot flags. The core can also write the status register directly through a write port, for example when it returns from a handler.

Status register layout, which other parts of the core decode:

| Bit(s) | Field |
|---|---|
| 30 | privileged mode |
| 29 | register bank |
| 28 | block |
| 15 | FPU disable |
| 7:4 | interrupt mask |

Top module: `exc_entry_seq`

## Requirements
- R1: If an exception is pending (`exc_valid_i`=1) when `take_i` is high, the exception is taken and the interrupt request is ignored. In that case `intevt_o` is unchanged and `expevt_o` receives the code.
- R2: If SR bit 28 (block) is set, a pending exception whose code is not 0x1E0 is taken as code 0x000. Code 0x1E0 keeps its own code.
- R3: If SR bit 28 is set and `sleeping_i` is 0, an interrupt request is not taken: no done pulse and no register change. If `sleeping_i` is 1, the request can be taken.
- R4: An interrupt is taken only if `irq_pend_i`=1 and `irq_level_i` is strictly greater than SR[7:4]. Otherwise no register changes and `done_o` stays low.
- R5: On entry, `ssr_o` gets the old SR, `sgr_o` gets `r15_i` and `spc_o` gets `pc_i`. SR bits 30, 29 and 28 are set, and `sleep_clr_o` pulses with `done_o`.
- R6: If `in_dslot_i`=1 on entry, the saved PC is `pc_i`-2 and `ds_clr_o` pulses with `done_o`. Otherwise `ds_clr_o` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15, set SR[7:4] to 0xF and load PC 0xA0000000.
- R8: Exception codes 0x040 and 0x060 load PC `vbr_i`+0x400.
- R9: Every other exception code loads PC `vbr_i`+0x100. For code 0x160 the saved PC is additionally advanced by 2.
- R10: A taken interrupt writes `irq_vector_i` to `intevt_o` and loads PC `vbr_i`+0x600. `expevt_o` is unchanged.
- R11: `done_o` is high for exactly the cycle after an accepted take, with `pc_o` valid in that cycle. When `take_i` is low, no register changes.
- R12: Reset sets SR to 0x500000F0 (block and privileged set, mask 0xF) and all other registers and pulses to 0.
- R13: With no entry in the same cycle, `sr_wr_i`=1 loads `sr_wr_data_i` into SR at the next edge. An entry has priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Request to evaluate entry this cycle |
| exc_valid_i | input | 1 | An exception code is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Hardware interrupt request |
| irq_pend_i | input | 1 | Controller has a pending vector |
| irq_vector_i | input | 12 | Pending interrupt vector |
| irq_level_i | input | 4 | Priority level of pending vector |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current general register 15 |
| vbr_i | input | 32 | Vector base |
| sleeping_i | input | 1 | Core is in sleep |
| in_dslot_i | input | 1 | Faulting instruction is in a delay slot |
| sr_wr_i | input | 1 | Direct SR write enable |
| sr_wr_data_i | input | 32 | Direct SR write value |
| sr_o | output | 32 | Status register |
| ssr_o | output | 32 | Saved status register |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 12 | Last exception code taken |
| intevt_o | output | 12 | Last interrupt vector taken |
| pc_o | output | 32 | Handler address |
| done_o | output | 1 | One-cycle pulse: entry completed |
| sleep_clr_o | output | 1 | Pulse: clear core sleep flag |
| ds_clr_o | output | 1 | Pulse: clear core delay-slot flags |

## Verification
Some properties are checked on every cycle by the assertions:

- A done pulse always follows a take.
- Every entry leaves the block, privileged and bank bits set.
- A taken interrupt had a level above the old mask.
- An exception present at the take always wins over an interrupt.
- A blocked non-exempt exception always becomes the reset code with the reset handler address.
- Nothing changes without a take or a write.

Only the directed scenarios can show the exact handler addresses per code class, the saved-PC arithmetic for delay slots and the trap code, the masking of sleep-dependent interrupts, and the exact values saved into the shadow registers.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int SR_MD_BIT    = 30;
  localparam int SR_RB_BIT    = 29;
  localparam int SR_BL_BIT    = 28;
  localparam int SR_FD_BIT    = 15;
  localparam int SR_IMASK_LSB = 4;

  localparam int CODE_RESET     = 'h000;
  localparam int CODE_MANUAL    = 'h020;
  localparam int CODE_MULTIHIT  = 'h140;
  localparam int CODE_TLB_RD    = 'h040;
  localparam int CODE_TLB_WR    = 'h060;
  localparam int CODE_TRAP      = 'h160;
  localparam int CODE_BL_EXEMPT = 'h1E0;

  localparam int OFS_GENERAL = 'h100;
  localparam int OFS_TLBMISS = 'h400;
  localparam int OFS_IRQ     = 'h600;
  localparam longint RESET_HANDLER = 64'hA000_0000;

  typedef enum logic [1:0] {
    ENTRY_NONE = 2'd0,
    ENTRY_EXC  = 2'd1,
    ENTRY_IRQ  = 2'd2
  } entry_kind_e;

endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              irq_pend,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [LVL_W-1:0]  imask,
  input  logic              blocked,
  input  logic              sleeping,
  output entry_kind_e       kind,
  output logic [CODE_W-1:0] eff_code
);

  logic irq_masked_by_bl;
  logic irq_level_ok;
  logic irq_wins;

  // Exceptions take precedence; interrupts considered only when none pending.
  assign irq_masked_by_bl = blocked && !sleeping;
  assign irq_level_ok     = irq_pend && (irq_level > imask);
  assign irq_wins         = irq_req && !exc_valid && irq_level_ok && !irq_masked_by_bl;

  always_comb begin
    if (exc_valid)     kind = ENTRY_EXC;
    else if (irq_wins) kind = ENTRY_IRQ;
    else               kind = ENTRY_NONE;
  end

  // While blocked, every code except the exempt one is forced to reset.
  assign eff_code = (blocked && exc_code != CODE_W'(CODE_BL_EXEMPT))
                    ? CODE_W'(CODE_RESET) : exc_code;

endmodule

// File: rtl/exc_entry_target.sv
module exc_entry_target
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4
) (
  input  entry_kind_e       kind,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   sr_cur,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_dslot,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   saved_pc
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);

  function automatic logic is_reset_class(input logic [CODE_W-1:0] c);
    return (c == CODE_W'(CODE_RESET)) || (c == CODE_W'(CODE_MANUAL)) ||
           (c == CODE_W'(CODE_MULTIHIT));
  endfunction

  function automatic logic is_tlb_miss(input logic [CODE_W-1:0] c);
    return (c == CODE_W'(CODE_TLB_RD)) || (c == CODE_W'(CODE_TLB_WR));
  endfunction

  function automatic logic [XLEN-1:0] handler_pc(input entry_kind_e k,
                                                 input logic [CODE_W-1:0] c,
                                                 input logic [XLEN-1:0] base);
    if (k == ENTRY_IRQ)     return base + XLEN'(OFS_IRQ);
    if (is_reset_class(c))  return XLEN'(RESET_HANDLER);
    if (is_tlb_miss(c))     return base + XLEN'(OFS_TLBMISS);
    return base + XLEN'(OFS_GENERAL);
  endfunction

  function automatic logic [XLEN-1:0] resume_pc(input entry_kind_e k,
                                                input logic [CODE_W-1:0] c,
                                                input logic [XLEN-1:0] p,
                                                input logic ds);
    logic [XLEN-1:0] r;
    r = ds ? (p - INSN_BYTES) : p;
    if (k == ENTRY_EXC && c == CODE_W'(CODE_TRAP)) r = r + INSN_BYTES;
    return r;
  endfunction

  always_comb begin
    new_sr = sr_cur;
    new_sr[SR_BL_BIT] = 1'b1;
    new_sr[SR_MD_BIT] = 1'b1;
    new_sr[SR_RB_BIT] = 1'b1;
    if (kind == ENTRY_EXC && is_reset_class(code)) begin
      new_sr[SR_FD_BIT] = 1'b0;
      new_sr[SR_IMASK_LSB +: LVL_W] = '1;
    end
  end

  assign new_pc   = handler_pc(kind, code, vbr);
  assign saved_pc = resume_pc(kind, code, pc, in_dslot);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_pend_i,
  input  logic [CODE_W-1:0] irq_vector_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              sleeping_i,
  input  logic              in_dslot_i,
  input  logic              sr_wr_i,
  input  logic [XLEN-1:0]   sr_wr_data_i,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              done_o,
  output logic              sleep_clr_o,
  output logic              ds_clr_o
);

  localparam logic [XLEN-1:0] SR_RESET =
    (XLEN'(1) << SR_BL_BIT) | (XLEN'(1) << SR_MD_BIT) |
    (XLEN'((1 << LVL_W) - 1) << SR_IMASK_LSB);

  logic [XLEN-1:0]   sr_q, ssr_q, spc_q, sgr_q, pc_q;
  logic [CODE_W-1:0] expevt_q, intevt_q;
  logic              done_q, sleep_clr_q, ds_clr_q, took_irq_q;

  entry_kind_e       arb_kind;
  logic [CODE_W-1:0] arb_code;
  logic [XLEN-1:0]   tgt_pc, tgt_sr, tgt_spc;
  logic              entry_fire;
  logic [LVL_W-1:0]  cur_imask;

  assign cur_imask = sr_q[SR_IMASK_LSB +: LVL_W];

  exc_entry_arbiter #(.CODE_W(CODE_W), .LVL_W(LVL_W)) arb_i (
    .exc_valid (exc_valid_i),
    .exc_code  (exc_code_i),
    .irq_req   (irq_req_i),
    .irq_pend  (irq_pend_i),
    .irq_level (irq_level_i),
    .imask     (cur_imask),
    .blocked   (sr_q[SR_BL_BIT]),
    .sleeping  (sleeping_i),
    .kind      (arb_kind),
    .eff_code  (arb_code)
  );

  exc_entry_target #(.XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W)) tgt_i (
    .kind     (arb_kind),
    .code     (arb_code),
    .sr_cur   (sr_q),
    .pc       (pc_i),
    .vbr      (vbr_i),
    .in_dslot (in_dslot_i),
    .new_pc   (tgt_pc),
    .new_sr   (tgt_sr),
    .saved_pc (tgt_spc)
  );

  assign entry_fire = take_i && (arb_kind != ENTRY_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q        <= SR_RESET;
      ssr_q       <= '0;
      spc_q       <= '0;
      sgr_q       <= '0;
      pc_q        <= '0;
      expevt_q    <= '0;
      intevt_q    <= '0;
      done_q      <= 1'b0;
      sleep_clr_q <= 1'b0;
      ds_clr_q    <= 1'b0;
      took_irq_q  <= 1'b0;
    end else begin
      done_q      <= entry_fire;
      sleep_clr_q <= entry_fire;
      ds_clr_q    <= entry_fire && in_dslot_i;
      took_irq_q  <= entry_fire && (arb_kind == ENTRY_IRQ);
      if (entry_fire) begin
        ssr_q <= sr_q;
        spc_q <= tgt_spc;
        sgr_q <= r15_i;
        sr_q  <= tgt_sr;
        pc_q  <= tgt_pc;
        if (arb_kind == ENTRY_EXC) expevt_q <= arb_code;
        else                       intevt_q <= irq_vector_i;
      end else if (sr_wr_i) begin
        sr_q <= sr_wr_data_i;
      end
    end
  end

  assign sr_o        = sr_q;
  assign ssr_o       = ssr_q;
  assign spc_o       = spc_q;
  assign sgr_o       = sgr_q;
  assign expevt_o    = expevt_q;
  assign intevt_o    = intevt_q;
  assign pc_o        = pc_q;
  assign done_o      = done_q;
  assign sleep_clr_o = sleep_clr_q;
  assign ds_clr_o    = ds_clr_q;

  assert_done_follows_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(take_i));

  assert_idle_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !sr_wr_i) |=> ($stable(sr_o) && $stable(ssr_o) && $stable(spc_o) &&
                               $stable(pc_o) && $stable(expevt_o) && $stable(intevt_o)));

  assert_entry_sets_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT] && sleep_clr_o));

  assert_irq_above_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    took_irq_q |-> ($past(irq_level_i) > ssr_o[SR_IMASK_LSB +: LVL_W]));

  assert_exc_beats_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(exc_valid_i)) |-> !took_irq_q);

  assert_blocked_to_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(exc_valid_i) && ssr_o[SR_BL_BIT] &&
     $past(exc_code_i) != CODE_W'(CODE_BL_EXEMPT))
    |-> (expevt_o == '0 && pc_o == XLEN'(RESET_HANDLER)));

endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 0, exc_valid_i = 0, irq_req_i = 0, irq_pend_i = 0;
  logic [11:0] exc_code_i = 0, irq_vector_i = 0;
  logic [3:0]  irq_level_i = 0;
  logic [31:0] pc_i = 0, r15_i = 0, vbr_i = 0, sr_wr_data_i = 0;
  logic        sleeping_i = 0, in_dslot_i = 0, sr_wr_i = 0;
  logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
  logic [11:0] expevt_o, intevt_o;
  logic        done_o, sleep_clr_o, ds_clr_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .exc_valid_i(exc_valid_i),
    .exc_code_i(exc_code_i), .irq_req_i(irq_req_i), .irq_pend_i(irq_pend_i),
    .irq_vector_i(irq_vector_i), .irq_level_i(irq_level_i), .pc_i(pc_i),
    .r15_i(r15_i), .vbr_i(vbr_i), .sleeping_i(sleeping_i), .in_dslot_i(in_dslot_i),
    .sr_wr_i(sr_wr_i), .sr_wr_data_i(sr_wr_data_i), .sr_o(sr_o), .ssr_o(ssr_o),
    .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt_o), .intevt_o(intevt_o),
    .pc_o(pc_o), .done_o(done_o), .sleep_clr_o(sleep_clr_o), .ds_clr_o(ds_clr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_sr(input logic [31:0] v);
    sr_wr_i = 1; sr_wr_data_i = v;
    @(negedge clk);
    sr_wr_i = 0;
    @(negedge clk);
    chk("R13 sr write", sr_o, v);
  endtask

  task automatic clear_req();
    exc_valid_i = 0; irq_req_i = 0; irq_pend_i = 0; sleeping_i = 0; in_dslot_i = 0;
  endtask

  task automatic pulse_take();
    take_i = 1;
    @(negedge clk);
    take_i = 0;
    clear_req();
  endtask

  task automatic exc_case(input logic [11:0] code, input logic ds,
                          input logic [31:0] old_sr, input logic [31:0] exp_sr,
                          input logic [31:0] exp_pc, input logic [31:0] exp_spc,
                          input logic [11:0] exp_code, input string tag);
    logic [11:0] prev_int;
    set_sr(old_sr);
    prev_int = intevt_o;
    exc_valid_i = 1; exc_code_i = code; in_dslot_i = ds;
    pc_i = 32'h0000_1000; r15_i = 32'h0000_2222; vbr_i = 32'h8000_0000;
    pulse_take();
    chk({tag, " done"}, {31'd0, done_o}, 32'd1);
    chk({tag, " pc"}, pc_o, exp_pc);
    chk({tag, " sr"}, sr_o, exp_sr);
    chk({tag, " ssr R5"}, ssr_o, old_sr);
    chk({tag, " spc"}, spc_o, exp_spc);
    chk({tag, " sgr R5"}, sgr_o, 32'h0000_2222);
    chk({tag, " expevt"}, {20'd0, expevt_o}, {20'd0, exp_code});
    chk({tag, " intevt R10"}, {20'd0, intevt_o}, {20'd0, prev_int});
    chk({tag, " ds_clr R6"}, {31'd0, ds_clr_o}, {31'd0, ds});
    @(negedge clk);
    chk({tag, " done single R11"}, {31'd0, done_o}, 32'd0);
  endtask

  task automatic test_reset();
    chk("R12 sr", sr_o, 32'h5000_00F0);
    chk("R12 pc", pc_o, 32'h0);
    chk("R12 done", {31'd0, done_o}, 32'd0);
    chk("R12 ssr", ssr_o, 32'h0);
  endtask

  task automatic test_general();
    exc_case(12'h180, 0, 32'h0000_0000, 32'h7000_0000, 32'h8000_0100,
             32'h0000_1000, 12'h180, "R9 general");
    chk("R5 sleep_clr", {31'd0, sleep_clr_o}, 32'd0);
  endtask

  task automatic test_tlb();
    exc_case(12'h040, 0, 32'h0000_0010, 32'h7000_0010, 32'h8000_0400,
             32'h0000_1000, 12'h040, "R8 tlb read");
    exc_case(12'h060, 0, 32'h0000_0000, 32'h7000_0000, 32'h8000_0400,
             32'h0000_1000, 12'h060, "R8 tlb write");
  endtask

  task automatic test_trap_and_slot();
    exc_case(12'h160, 0, 32'h0, 32'h7000_0000, 32'h8000_0100,
             32'h0000_1002, 12'h160, "R9 trap");
    exc_case(12'h160, 1, 32'h0, 32'h7000_0000, 32'h8000_0100,
             32'h0000_1000, 12'h160, "R6 trap in slot");
    exc_case(12'h0E0, 1, 32'h0, 32'h7000_0000, 32'h8000_0100,
             32'h0000_0FFE, 12'h0E0, "R6 slot");
  endtask

  task automatic test_reset_class();
    exc_case(12'h140, 0, 32'h0000_8030, 32'h7000_00F0, 32'hA000_0000,
             32'h0000_1000, 12'h140, "R7 multihit");
    exc_case(12'h020, 0, 32'h0000_8000, 32'h7000_00F0, 32'hA000_0000,
             32'h0000_1000, 12'h020, "R7 manual");
  endtask

  task automatic test_blocked_exc();
    exc_case(12'h0A0, 0, 32'h1000_0000, 32'h7000_00F0, 32'hA000_0000,
             32'h0000_1000, 12'h000, "R2 blocked");
    exc_case(12'h1E0, 0, 32'h1000_0000, 32'h7000_0000, 32'h8000_0100,
             32'h0000_1000, 12'h1E0, "R2 exempt");
  endtask

  task automatic test_priority();
    logic [11:0] prev_int;
    set_sr(32'h0);
    prev_int = intevt_o;
    exc_valid_i = 1; exc_code_i = 12'h180;
    irq_req_i = 1; irq_pend_i = 1; irq_level_i = 4'hF; irq_vector_i = 12'h3C0;
    vbr_i = 32'h0000_4000;
    pulse_take();
    chk("R1 expevt", {20'd0, expevt_o}, 32'h180);
    chk("R1 intevt unchanged", {20'd0, intevt_o}, {20'd0, prev_int});
    chk("R1 pc", pc_o, 32'h0000_4100);
  endtask

  task automatic irq_try(input logic [31:0] old_sr, input logic pend, input logic [3:0] lvl,
                         input logic slp, input logic expect_take, input string tag);
    logic [31:0] prev_pc;
    logic [11:0] prev_int, prev_exp;
    set_sr(old_sr);
    prev_pc = pc_o; prev_int = intevt_o; prev_exp = expevt_o;
    irq_req_i = 1; irq_pend_i = pend; irq_level_i = lvl; sleeping_i = slp;
    irq_vector_i = 12'h5A0; vbr_i = 32'h0C00_0000; pc_i = 32'h0000_3000;
    pulse_take();
    chk({tag, " done"}, {31'd0, done_o}, {31'd0, expect_take});
    if (expect_take) begin
      chk({tag, " R10 pc"}, pc_o, 32'h0C00_0600);
      chk({tag, " R10 intevt"}, {20'd0, intevt_o}, 32'h5A0);
      chk({tag, " R10 expevt"}, {20'd0, expevt_o}, {20'd0, prev_exp});
      chk({tag, " R5 sleep_clr"}, {31'd0, sleep_clr_o}, 32'd1);
      chk({tag, " R5 spc"}, spc_o, 32'h0000_3000);
    end else begin
      chk({tag, " pc kept"}, pc_o, prev_pc);
      chk({tag, " intevt kept"}, {20'd0, intevt_o}, {20'd0, prev_int});
      chk({tag, " sr kept"}, sr_o, old_sr);
    end
  endtask

  task automatic test_irq();
    irq_try(32'h0000_0050, 1, 4'd5, 0, 0, "R4 level equal");
    irq_try(32'h0000_0050, 1, 4'd6, 0, 1, "R4 level above");
    irq_try(32'h0000_0000, 0, 4'd9, 0, 0, "R4 none pending");
    irq_try(32'h1000_0000, 1, 4'd5, 0, 0, "R3 blocked awake");
    irq_try(32'h1000_0000, 1, 4'd5, 1, 1, "R3 blocked asleep");
  endtask

  task automatic test_no_take();
    logic [31:0] prev_pc;
    set_sr(32'h0);
    prev_pc = pc_o;
    exc_valid_i = 1; exc_code_i = 12'h180;
    @(negedge clk);
    @(negedge clk);
    chk("R11 no take pc", pc_o, prev_pc);
    chk("R11 no take done", {31'd0, done_o}, 32'd0);
    chk("R11 no take sr", sr_o, 32'h0);
    clear_req();
    // Entry wins over a simultaneous SR write
    sr_wr_i = 1; sr_wr_data_i = 32'h0000_00A0;
    exc_valid_i = 1; exc_code_i = 12'h180;
    pulse_take();
    sr_wr_i = 0;
    chk("R13 entry beats write", sr_o, 32'h7000_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_general();
    test_tlb();
    test_trap_and_slot();
    test_reset_class();
    test_blocked_exc();
    test_priority();
    test_irq();
    test_no_take();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule